// File: doc/BRIEF.md
# Receive FIFO with Trigger Level and Character Timeout

This block is the receive half of a PC-style serial port buffer. Bytes that a separate deserialiser has already assembled arrive on a valid/data pair, or as a break event. They are queued in a 16-entry byte FIFO, and the host removes them with a read strobe. A write to the FIFO control register turns buffering on or off, flushes the receive queue, requests a flush of the transmit queue, selects the DMA signalling mode and sets the receive trigger level. The control register value is kept as the write data ANDed with 0xC9. When buffering is off, the block falls back to a single holding byte.

A character timeout tells the host that bytes are waiting below the trigger level. The length of one character is worked out from the programmed frame format (`frame_cfg`). Each bit counts as 16 baud ticks, and the timeout lasts four characters. The timer is a small state machine with three states. TM_IDLE means no timer is running. TM_COUNT means a down-counter is counting baud ticks. TM_PEND means the timeout has fired.

The transitions are:
- idle→count on a restart event.
- count→count (reload) on a further restart.
- count→pend when the counter expires while data is queued.
- count→idle when it expires with the queue empty.
- pend→idle on a host read that leaves the queue empty.
- pend→count on a host read that leaves data behind.
- any state→idle when the receive queue is flushed.

Top module: `rx_fifo_ctl`

## Requirements
- R1: A write on `ctl_we` stores `ctl_wdata & 8'hC9` on `ctl_value`. Bit 0 is the FIFO enable, bit 3 is the DMA mode and bits 7:6 are the trigger code. Bits 1 and 2 are actions and are never stored.
- R2: Trigger codes 0, 1, 2 and 3 select levels of 1, 4, 8 and 14 bytes. With the FIFO on, `level_hit` is high when `rx_count` is at or above the level.
- R3: A write with bit 2 set, or a write that changes the enable bit, pulses `tx_flush` high for the one cycle after the write. A write that changes the enable bit also empties the receive queue.
- R4: A write with bit 1 set, or one that toggles the enable, empties the receive queue, clears `data_ready` and `break_seen`, stops the timer and clears `timeout_pend`.
- R5: With the FIFO on, bytes come out in arrival order and up to 16 are held. A byte arriving at 16 is dropped and sets `overrun`. A `status_rd` pulse clears `overrun` and `break_seen`.
- R6: With the FIFO on, each received byte, and each host read that leaves data queued, restarts a four-character timer. If the timer expires with data still queued, `timeout_pend` rises. Any host read clears it.
- R7: One character lasts 16 baud ticks per bit. The bit count is 1 start bit, plus `frame_cfg[1:0]`+5 data bits, plus 1 parity bit if `frame_cfg[3]` is set, plus 2 stop bits if `frame_cfg[2]` is set and 1 otherwise.
- R8: With the FIFO on, reading an empty queue returns 0x00. A read that takes the last byte clears `data_ready` and `break_seen`.
- R9: A `rx_break` pulse queues a 0x00 byte and sets both `break_seen` and `data_ready`.
- R10: With the FIFO off, one byte is held and `rx_count` shows 0 or 1. A new byte arriving while `data_ready` is set raises `overrun` and replaces the held byte. A host read clears `data_ready`.
- R11: After reset, `ctl_value` is 0 (FIFO off), the count is 0 and every flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | FIFO control register write strobe |
| ctl_wdata | input | 8 | FIFO control write value |
| frame_cfg | input | 4 | Frame format: [1:0] data length, [2] two stop bits, [3] parity |
| baud_tick | input | 1 | One pulse per sixteenth of a bit time |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break condition strobe |
| host_rd | input | 1 | Host pop strobe |
| status_rd | input | 1 | Host line status read; clears overrun and break |
| host_rdata | output | 8 | Byte presented to the host |
| ctl_value | output | 8 | Stored control value |
| tx_flush | output | 1 | One-cycle transmit queue flush request |
| data_ready | output | 1 | Receive data available |
| overrun | output | 1 | A byte was lost |
| break_seen | output | 1 | A break was received |
| rx_count | output | 5 | Bytes held |
| level_hit | output | 1 | Count has reached the trigger level |
| timeout_pend | output | 1 | Character timeout has fired |

## Verification
The assertions check every cycle that:
- flushes empty the queue and cancel a pending timeout;
- a full queue turns an arrival into an overrun;
- a last-byte read drops `data_ready`;
- a break sets its flags;
- `timeout_pend` only ever rises while data is held;
- a host read always clears it.

Some behaviour can only be shown by the bench's directed scenarios:
- the exact timeout length for several frame formats;
- the arrival ordering through the ring;
- the four trigger thresholds;
- the 0xC9 masking;
- holding-register overwrite.

// File: rtl/rx_fifo_pkg.sv
`timescale 1ns/1ps
package rx_fifo_pkg;

    typedef enum logic [1:0] {
        TM_IDLE  = 2'd0,
        TM_COUNT = 2'd1,
        TM_PEND  = 2'd2
    } tm_state_e;

    // trigger code -> byte threshold (non-linear)
    function automatic logic [4:0] trig_level(input logic [1:0] code);
        logic [4:0] lvl;
        unique case (code)
            2'd0:    lvl = 5'd1;
            2'd1:    lvl = 5'd4;
            2'd2:    lvl = 5'd8;
            default: lvl = 5'd14;
        endcase
        return lvl;
    endfunction

    // bits per character: start + data + optional parity + stop(s)
    function automatic logic [3:0] frame_bits(input logic [3:0] cfg);
        return 4'd7 + {2'b00, cfg[1:0]} + {3'b000, cfg[3]} + {3'b000, cfg[2]};
    endfunction

endpackage

// File: rtl/rx_ctl_decode.sv
`timescale 1ns/1ps
module rx_ctl_decode (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_value,
    output logic       rx_clr,
    output logic       tx_flush
);
    logic [7:0] ctl_q;
    logic       flush_q;
    logic       en_flip;

    always_comb begin
        en_flip = ctl_we & (ctl_wdata[0] ^ ctl_q[0]);
        rx_clr  = (ctl_we & ctl_wdata[1]) | en_flip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= 8'h00;
            flush_q <= 1'b0;
        end else begin
            flush_q <= (ctl_we & ctl_wdata[2]) | en_flip;
            if (ctl_we)
                ctl_q <= ctl_wdata & 8'hC9;
        end
    end

    assign ctl_value = ctl_q;
    assign tx_flush  = flush_q;

    // R3: toggling the enable produces a transmit flush request next cycle
    a_r3_flip_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && (ctl_wdata[0] != ctl_value[0])) |=> tx_flush);
    // R1: action bits and unused bits never appear in the stored value
    a_r1_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> ((ctl_value & 8'h36) == 8'h00));
endmodule

// File: rtl/rx_byte_ring.sv
`timescale 1ns/1ps
module rx_byte_ring #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    // pointer wrap: plain increment when the depth is a power of two
    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign wr_nxt = wr_q + 1'b1;
            assign rd_nxt = rd_q + 1'b1;
        end else begin : g_wrap
            assign wr_nxt = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            assign rd_nxt = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
        end
    endgenerate

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wr_q <= wr_nxt;
            if (pop_ok)  rd_q <= rd_nxt;
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clr)
            mem_q[wr_q] <= din;
    end

    assign head  = mem_q[rd_q];
    assign count = cnt_q;

    // R5: occupancy never exceeds the depth
    a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R5: a push into a full ring without a pop leaves it full
    a_r5_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> full);
endmodule

// File: rtl/rx_char_timer.sv
`timescale 1ns/1ps
module rx_char_timer
    import rx_fifo_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int CHARS = 4,
    localparam int MAX_TICKS = 12 * OVS * CHARS,
    localparam int CNT_W     = $clog2(MAX_TICKS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] frame_cfg,
    input  logic       baud_tick,
    input  logic       restart,
    input  logic       cancel,
    input  logic       rd_clr,
    input  logic       has_data,
    output logic       timeout_pend
);
    tm_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, reload;

    assign reload = CNT_W'(32'(frame_bits(frame_cfg)) * OVS * CHARS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TM_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (cancel) begin
            state_d = TM_IDLE;
            cnt_d   = '0;
        end else if (rd_clr) begin
            state_d = restart ? TM_COUNT : TM_IDLE;
            cnt_d   = restart ? reload : '0;
        end else begin
            unique case (state_q)
                TM_IDLE: begin
                    if (restart) begin
                        state_d = TM_COUNT;
                        cnt_d   = reload;
                    end
                end
                TM_COUNT: begin
                    if (restart) begin
                        cnt_d = reload;
                    end else if (baud_tick) begin
                        if (cnt_q <= CNT_W'(1)) begin
                            state_d = has_data ? TM_PEND : TM_IDLE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                TM_PEND: state_d = TM_PEND;
                default: state_d = TM_IDLE;
            endcase
        end
    end

    always_comb timeout_pend = (state_q == TM_PEND);

    // R6: the timeout only fires while data is queued
    a_r6_pend_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_pend) |-> $past(has_data));
    // R6: any host read clears the pending timeout
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> !timeout_pend);
    // R4: a receive flush cancels the timer
    a_r4_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> (!timeout_pend && state_q == TM_IDLE));
endmodule

// File: rtl/rx_fifo_ctl.sv
`timescale 1ns/1ps
module rx_fifo_ctl
    import rx_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OVS   = 16,
    parameter int CHARS = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [7:0]    ctl_wdata,
    input  logic [3:0]    frame_cfg,
    input  logic          baud_tick,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_break,
    input  logic          host_rd,
    input  logic          status_rd,
    output logic [7:0]    host_rdata,
    output logic [7:0]    ctl_value,
    output logic          tx_flush,
    output logic          data_ready,
    output logic          overrun,
    output logic          break_seen,
    output logic [CW-1:0] rx_count,
    output logic          level_hit,
    output logic          timeout_pend
);
    logic          rx_clr, fifo_on;
    logic          rx_evt, push_ok, pop_ok;
    logic [7:0]    rx_byte, ring_head, hold_q;
    logic [CW-1:0] ring_count;
    logic [CW:0]   remain;
    logic          ring_full, ring_empty;
    logic          dr_q, ovr_q, brk_q;
    logic          restart;

    rx_ctl_decode u_dec (
        .clk, .rst_n, .ctl_we, .ctl_wdata,
        .ctl_value, .rx_clr, .tx_flush
    );

    assign fifo_on = ctl_value[0];
    assign rx_evt  = rx_valid | rx_break;
    assign rx_byte = rx_break ? 8'h00 : rx_data;
    assign push_ok = fifo_on & rx_evt & ~ring_full;
    assign pop_ok  = fifo_on & host_rd & ~ring_empty;
    assign remain  = {1'b0, ring_count} + (CW+1)'(push_ok) - (CW+1)'(pop_ok);

    rx_byte_ring #(.DEPTH(DEPTH), .W(8)) u_ring (
        .clk, .rst_n,
        .clr   (rx_clr),
        .push  (fifo_on & rx_evt),
        .pop   (fifo_on & host_rd),
        .din   (rx_byte),
        .head  (ring_head),
        .count (ring_count),
        .full  (ring_full),
        .empty (ring_empty)
    );

    assign restart = fifo_on & (rx_valid | (pop_ok & (remain != '0)));

    rx_char_timer #(.OVS(OVS), .CHARS(CHARS)) u_tmr (
        .clk, .rst_n, .frame_cfg, .baud_tick,
        .restart,
        .cancel   (rx_clr),
        .rd_clr   (fifo_on & host_rd),
        .has_data (~ring_empty),
        .timeout_pend
    );

    // line flags: later assignments take priority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_q   <= 1'b0;
            ovr_q  <= 1'b0;
            brk_q  <= 1'b0;
            hold_q <= 8'h00;
        end else begin
            if (status_rd) begin
                ovr_q <= 1'b0;
                brk_q <= 1'b0;
            end
            if (host_rd && (!fifo_on || remain == '0)) begin
                dr_q  <= 1'b0;
                brk_q <= 1'b0;
            end
            if (rx_evt) begin
                dr_q <= 1'b1;
                if (rx_break) brk_q <= 1'b1;
                if (fifo_on) begin
                    if (ring_full) ovr_q <= 1'b1;
                end else begin
                    if (dr_q && !host_rd) ovr_q <= 1'b1;
                    hold_q <= rx_byte;
                end
            end
            if (rx_clr) begin
                dr_q  <= 1'b0;
                brk_q <= 1'b0;
            end
        end
    end

    assign host_rdata = fifo_on ? (ring_empty ? 8'h00 : ring_head) : hold_q;
    assign data_ready = dr_q;
    assign overrun    = ovr_q;
    assign break_seen = brk_q;
    assign rx_count   = fifo_on ? ring_count : CW'(dr_q);
    assign level_hit  = fifo_on ? (32'(ring_count) >= 32'(trig_level(ctl_value[7:6]))) : dr_q;

    // R5: an arrival into a full queue is lost and flagged
    a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on && rx_valid && rx_count == CW'(DEPTH) && !host_rd && !ctl_we)
        |=> (overrun && rx_count == CW'(DEPTH)));
    // R8: reading the last byte drops data ready and break
    a_r8_last_read: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on && host_rd && rx_count == CW'(1) && !rx_evt)
        |=> (!data_ready && !break_seen));
    // R4: a receive flush empties the queue
    a_r4_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[1]) |=> (rx_count == '0 && !data_ready && !timeout_pend));
    // R9: break sets its flags
    a_r9_break_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_break && !ctl_we) |=> (break_seen && data_ready));
    // R10: holding register overwrite raises overrun
    a_r10_hold_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_on && data_ready && rx_valid && !host_rd && !ctl_we) |=> overrun);
endmodule

// File: tb/sim_rx_fifo_ctl.sv
`timescale 1ns/1ps
module sim_rx_fifo_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [3:0] frame_cfg = 4'h0;
    logic       baud_tick = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_break = 1'b0;
    logic       host_rd = 1'b0;
    logic       status_rd = 1'b0;
    logic [7:0] host_rdata, ctl_value;
    logic       tx_flush, data_ready, overrun, break_seen, level_hit, timeout_pend;
    logic [4:0] rx_count;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    rx_fifo_ctl u0 (
        .clk, .rst_n, .ctl_we, .ctl_wdata, .frame_cfg, .baud_tick,
        .rx_valid, .rx_data, .rx_break, .host_rd, .status_rd,
        .host_rdata, .ctl_value, .tx_flush, .data_ready, .overrun,
        .break_seen, .rx_count, .level_hit, .timeout_pend
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic rx_byte(input logic [7:0] d);
        @(negedge clk); rx_valid = 1'b1; rx_data = d;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic do_read(output logic [7:0] d);
        @(negedge clk); host_rd = 1'b1; #1 d = host_rdata;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic do_status;
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int tmo_ticks(input logic [3:0] cfg);
        return (7 + cfg[1:0] + cfg[3] + cfg[2]) * 16 * 4;
    endfunction

    task automatic t_reset;
        eq("R11 ctl", ctl_value, 8'h00);
        eq("R11 count", rx_count, 0);
        eq("R11 flags", {data_ready, overrun, break_seen, level_hit, timeout_pend, tx_flush}, 0);
    endtask

    task automatic t_decode;
        ctl_write(8'hFF);
        eq("R1 mask C9", ctl_value, 8'hC9);
        eq("R3 flush pulse", tx_flush, 1);
        idle(1);
        eq("R3 flush one cycle", tx_flush, 0);
        ctl_write(8'h09);
        eq("R1 dma kept", ctl_value, 8'h09);
        eq("R3 no flush", tx_flush, 0);
    endtask

    task automatic t_order;
        logic [7:0] d;
        ctl_write(8'h01);
        for (int i = 0; i < 16; i++) rx_byte(8'(i * 7 + 3));
        eq("R5 full count", rx_count, 16);
        eq("R5 no overrun yet", overrun, 0);
        rx_byte(8'hEE);
        eq("R5 overrun", overrun, 1);
        eq("R5 count kept", rx_count, 16);
        do_status;
        eq("R5 status clears", overrun, 0);
        for (int i = 0; i < 16; i++) begin
            do_read(d);
            eq("R5 order", d, 8'(i * 7 + 3));
        end
        eq("R8 empty drops ready", data_ready, 0);
        do_read(d);
        eq("R8 empty read zero", d, 8'h00);
    endtask

    task automatic t_trigger;
        ctl_write(8'h01);
        rx_byte(8'h11);
        eq("R2 level 1", level_hit, 1);
        ctl_write(8'h41);
        eq("R2 no clear on same enable", rx_count, 1);
        rx_byte(8'h12); rx_byte(8'h13);
        eq("R2 level 4 below", level_hit, 0);
        rx_byte(8'h14);
        eq("R2 level 4 at", level_hit, 1);
        ctl_write(8'h81);
        eq("R2 level 8 below", level_hit, 0);
        for (int i = 0; i < 4; i++) rx_byte(8'h20);
        eq("R2 level 8 at", level_hit, 1);
        ctl_write(8'hC1);
        eq("R2 level 14 below", level_hit, 0);
        for (int i = 0; i < 6; i++) rx_byte(8'h30);
        eq("R2 level 14 at", level_hit, 1);
        ctl_write(8'h03);
        eq("R4 flush count", rx_count, 0);
        eq("R4 flush ready", data_ready, 0);
    endtask

    task automatic t_timeout(input logic [3:0] cfg);
        logic [7:0] d;
        int n;
        frame_cfg = cfg;
        n = tmo_ticks(cfg);
        ctl_write(8'h03);
        rx_byte(8'h55);
        idle(n - 2);
        eq("R7 not yet", timeout_pend, 0);
        idle(4);
        eq("R7 fired", timeout_pend, 1);
        rx_byte(8'h56);
        eq("R6 arrival keeps pend", timeout_pend, 1);
        do_read(d);
        eq("R6 read clears", timeout_pend, 0);
        idle(n - 2);
        eq("R6 restart by read", timeout_pend, 0);
        idle(4);
        eq("R6 refire", timeout_pend, 1);
        do_read(d);
        eq("R6 last read clears", timeout_pend, 0);
        idle(n + 4);
        eq("R6 no fire when empty", timeout_pend, 0);
    endtask

    task automatic t_flush_timer;
        ctl_write(8'h03);
        frame_cfg = 4'h0;
        rx_byte(8'h01); rx_byte(8'h02);
        idle(tmo_ticks(4'h0) + 4);
        eq("R6 pend before flush", timeout_pend, 1);
        ctl_write(8'h03);
        eq("R4 flush clears pend", timeout_pend, 0);
        eq("R4 flush count", rx_count, 0);
        idle(tmo_ticks(4'h0) + 4);
        eq("R4 timer cancelled", timeout_pend, 0);
    endtask

    task automatic t_break;
        logic [7:0] d;
        ctl_write(8'h03);
        @(negedge clk); rx_break = 1'b1;
        @(negedge clk); rx_break = 1'b0;
        eq("R9 count", rx_count, 1);
        eq("R9 flags", {break_seen, data_ready}, 2'b11);
        do_read(d);
        eq("R9 zero byte", d, 8'h00);
        eq("R8 break cleared", {break_seen, data_ready}, 2'b00);
    endtask

    task automatic t_holding;
        logic [7:0] d;
        ctl_write(8'h01);
        rx_byte(8'h77); rx_byte(8'h78);
        ctl_write(8'h00);
        eq("R3 toggle empties", rx_count, 0);
        eq("R3 toggle flush", tx_flush, 1);
        eq("R3 toggle ready", data_ready, 0);
        rx_byte(8'hA5);
        eq("R10 one held", rx_count, 1);
        eq("R10 no overrun", overrun, 0);
        rx_byte(8'h3C);
        eq("R10 overrun", overrun, 1);
        do_read(d);
        eq("R10 overwrite", d, 8'h3C);
        eq("R10 read clears", data_ready, 0);
        do_status;
        eq("R5 status clears hold ovr", overrun, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_decode;
        t_order;
        t_trigger;
        t_timeout(4'h0);
        t_timeout(4'hF);
        t_timeout(4'h6);
        t_flush_timer;
        t_break;
        t_holding;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule